// File: doc/BRIEF.md
# MESI Coherence Line-State Controller

This block keeps the coherence state of every line of a write-back cache that shares a snooped system bus with other caches. Each line is in one of four states: Modified (dirty, held only here), Exclusive (clean, held only here), Shared (clean, possibly held elsewhere) or Invalid (nothing loaded). Local processor reads and writes, together with reads and writes by other bus masters that the cache observes, move lines between these states. The block raises the bus commands that follow from each move.

Data storage, tag comparison and bus arbitration sit outside the block. The surrounding cache supplies a line index and a hit flag for each local request and each snoop. Other caches drive a shared indication while a local miss is on the bus. Write misses go to memory and do not allocate a line. A write hit on a Shared line is written through to memory and then owned exclusively. A snooped read of a dirty line is answered with an immediate copy-back.

All outputs are combinational from the current state and the inputs of the same cycle. State changes take effect at the next clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cur_state` reports the state of line `lreq_idx` as I=0, S=1, E=2, M=3.
- R2: A local read with `lreq_hit`=1 on a valid line leaves the state unchanged and raises no command.
- R3: A local read that misses (`lreq_hit`=0, or the line is Invalid) fills the line as Shared when `shared_in`=1 and as Exclusive when `shared_in`=0.
- R4: A local write hit on a Shared line raises `mem_wr` in the same cycle and moves the line to Exclusive.
- R5: A local write hit on an Exclusive or Modified line leaves `mem_wr` low and moves the line to Modified.
- R6: A local write miss raises `mem_wr` and leaves the line state unchanged, so no line is allocated.
- R7: A snooped read hit on a Modified line raises `copyback` in the same cycle and moves the line to Shared. A snooped read hit on an Exclusive line moves it to Shared. A Shared line stays Shared.
- R8: A snooped write hit on any valid line moves that line to Invalid.
- R9: `snp_shared` is high in the snoop's own cycle exactly when `snp_valid` and `snp_hit` are high and the snooped line is valid.
- R10: A local read miss on a Modified line raises `evict_wb` in the same cycle. A read miss on an Exclusive, Shared or Invalid line does not.
- R11: When a snoop and a local request hit the same line in one cycle, the snoop is applied first. The local request, `cur_state` and the next state are then evaluated against the state the snoop leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lreq_valid | input | 1 | Local request present |
| lreq_write | input | 1 | Local request is a write (0 = read) |
| lreq_idx | input | IDX_W | Line index of the local request |
| lreq_hit | input | 1 | Tag matched for the local request |
| shared_in | input | 1 | Another cache holds the address of the local miss |
| snp_valid | input | 1 | Another master drives the bus (snoop present) |
| snp_write | input | 1 | Snooped access is a write |
| snp_idx | input | IDX_W | Line index of the snooped address |
| snp_hit | input | 1 | Tag matched for the snooped address |
| cur_state | output | 2 | State of line `lreq_idx` after any same-cycle snoop |
| mem_wr | output | 1 | Local write must also go to main memory |
| evict_wb | output | 1 | Dirty line being replaced must be written back |
| copyback | output | 1 | Dirty line must be copied to memory for the snoop |
| snp_shared | output | 1 | Shared response to the snooping master |

## Verification
Every command output (`mem_wr`, `evict_wb`, `copyback`, `snp_shared`) and `cur_state` is due in the same cycle as its stimulus. The state a stimulus produces becomes visible one clock later through `cur_state`. Each table row is therefore driven just after a falling edge and sampled shortly before the next rising edge. Transitions are checked by a following peek row, in which `lreq_valid` is low and the line is selected through `lreq_idx`. Snoop rows that select the snooped line show the state after the snoop in the same sample, because the snoop is applied first.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_e;
endpackage

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
(
   input  line_st_e cur,
   input  logic     snp_valid,
   input  logic     snp_write,
   input  logic     snp_hit,
   output line_st_e nxt,
   output logic     upd,
   output logic     resp,
   output logic     copyback
);
   logic act;

   // a snoop only matters when the tag matches a loaded line
   assign act      = snp_valid && snp_hit && (cur != ST_I);
   assign upd      = act;
   assign resp     = act;
   assign copyback = act && !snp_write && (cur == ST_M);

   always_comb begin
      nxt = cur;
      if (act) nxt = snp_write ? ST_I : ST_S;
   end
endmodule

// File: rtl/mesi_local_unit.sv
module mesi_local_unit
   import mesi_pkg::*;
(
   input  line_st_e st,
   input  logic     req_valid,
   input  logic     req_write,
   input  logic     req_hit,
   input  logic     shared_in,
   output line_st_e nxt,
   output logic     upd,
   output logic     mem_wr,
   output logic     evict_wb
);
   logic hit_eff;

   // a tag match on an Invalid line is still a miss
   assign hit_eff = req_hit && (st != ST_I);

   always_comb begin
      nxt      = st;
      upd      = 1'b0;
      mem_wr   = 1'b0;
      evict_wb = 1'b0;
      if (req_valid) begin
         if (!req_write) begin
            if (!hit_eff) begin
               upd      = 1'b1;
               nxt      = shared_in ? ST_S : ST_E;
               evict_wb = (st == ST_M);
            end
         end else if (hit_eff) begin
            upd = 1'b1;
            if (st == ST_S) begin
               mem_wr = 1'b1;
               nxt    = ST_E;
            end else begin
               nxt = ST_M;
            end
         end else begin
            mem_wr = 1'b1;
         end
      end
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter bit ASYNC_RESET = 1'b1,
   localparam int IDX_W      = $clog2(NUM_LINES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lreq_valid,
   input  logic             lreq_write,
   input  logic [IDX_W-1:0] lreq_idx,
   input  logic             lreq_hit,
   input  logic             shared_in,
   input  logic             snp_valid,
   input  logic             snp_write,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic             snp_hit,
   output logic [1:0]       cur_state,
   output logic             mem_wr,
   output logic             evict_wb,
   output logic             copyback,
   output logic             snp_shared
);
   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("mesi_line_ctrl: NUM_LINES must be a power of two of at least 2");
   end

   line_st_e                 st_q [NUM_LINES];
   logic [2*NUM_LINES-1:0]   line_flat;
   line_st_e                 snp_cur, snp_nxt, lcl_raw, lcl_cur, lcl_nxt;
   logic                     snp_upd, lcl_upd, same_line;

   assign snp_cur = st_q[snp_idx];
   assign lcl_raw = st_q[lreq_idx];

   mesi_snoop_unit u_snoop (
      .cur       (snp_cur),
      .snp_valid (snp_valid),
      .snp_write (snp_write),
      .snp_hit   (snp_hit),
      .nxt       (snp_nxt),
      .upd       (snp_upd),
      .resp      (snp_shared),
      .copyback  (copyback)
   );

   // the snoop goes first: the local side sees the state the snoop leaves
   assign same_line = snp_upd && (snp_idx == lreq_idx);
   assign lcl_cur   = same_line ? snp_nxt : lcl_raw;
   assign cur_state = lcl_cur;

   mesi_local_unit u_local (
      .st        (lcl_cur),
      .req_valid (lreq_valid),
      .req_write (lreq_write),
      .req_hit   (lreq_hit),
      .shared_in (shared_in),
      .nxt       (lcl_nxt),
      .upd       (lcl_upd),
      .mem_wr    (mem_wr),
      .evict_wb  (evict_wb)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      line_st_e d;
      always_comb begin
         if (lcl_upd && lreq_idx == IDX_W'(i))      d = lcl_nxt;
         else if (snp_upd && snp_idx == IDX_W'(i))  d = snp_nxt;
         else                                       d = st_q[i];
      end

      if (ASYNC_RESET) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[i] <= ST_I;
            else        st_q[i] <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) st_q[i] <= ST_I;
            else        st_q[i] <= d;
         end
      end

      assign line_flat[2*i +: 2] = st_q[i];
   end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
   parameter int NUM_LINES = 16,
   localparam int IDX_W    = $clog2(NUM_LINES)
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic                   lreq_valid,
   input logic                   lreq_write,
   input logic [IDX_W-1:0]       lreq_idx,
   input logic                   lreq_hit,
   input logic                   shared_in,
   input logic                   snp_valid,
   input logic                   snp_write,
   input logic [IDX_W-1:0]       snp_idx,
   input logic                   snp_hit,
   input logic                   mem_wr,
   input logic                   copyback,
   input logic                   snp_shared,
   input logic [2*NUM_LINES-1:0] line_flat
);
   function automatic logic [1:0] st_at(input logic [2*NUM_LINES-1:0] v,
                                        input logic [IDX_W-1:0] i);
      return v[2*i +: 2];
   endfunction

   logic [1:0] lst, sst;
   logic       coll, lsnp;
   assign lst  = st_at(line_flat, lreq_idx);
   assign sst  = st_at(line_flat, snp_idx);
   assign lsnp = snp_valid && snp_hit && (snp_idx == lreq_idx);
   assign coll = lreq_valid && (snp_idx == lreq_idx);

   AST_RESET_ALL_INVALID: assert property (@(posedge clk)
      !rst_n |=> line_flat == '0); // R1

   AST_READ_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_valid && !lreq_write && lreq_hit && lst != 2'd0 && !lsnp
      |=> st_at(line_flat, $past(lreq_idx)) == $past(lst)); // R2

   AST_READ_MISS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_valid && !lreq_write && (!lreq_hit || lst == 2'd0) && !lsnp
      |=> st_at(line_flat, $past(lreq_idx)) == ($past(shared_in) ? 2'd1 : 2'd2)); // R3

   AST_WR_SHARED_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_valid && lreq_write && lreq_hit && lst == 2'd1 && !lsnp
      |=> st_at(line_flat, $past(lreq_idx)) == 2'd2 && $past(mem_wr)); // R4

   AST_WR_OWNED_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_valid && lreq_write && lreq_hit && lst[1] && !lsnp
      |=> st_at(line_flat, $past(lreq_idx)) == 2'd3 && !$past(mem_wr)); // R5

   AST_WR_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_valid && lreq_write && (!lreq_hit || lst == 2'd0) && !lsnp
      |=> st_at(line_flat, $past(lreq_idx)) == $past(lst)); // R6

   AST_SNOOP_READ_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && !snp_write && snp_hit && sst != 2'd0 && !coll
      |=> st_at(line_flat, $past(snp_idx)) == 2'd1); // R7

   AST_COPYBACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      copyback |-> snp_valid && !snp_write && snp_hit); // R7

   AST_SNOOP_WRITE_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_write && snp_hit && !coll
      |=> st_at(line_flat, $past(snp_idx)) == 2'd0); // R8

   AST_SHARED_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> snp_valid && snp_hit); // R9

   AST_SNOOP_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_valid && lreq_write && snp_valid && snp_write && snp_hit &&
      snp_idx == lreq_idx |=> st_at(line_flat, $past(lreq_idx)) == 2'd0); // R11
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lreq_valid (lreq_valid),
   .lreq_write (lreq_write),
   .lreq_idx   (lreq_idx),
   .lreq_hit   (lreq_hit),
   .shared_in  (shared_in),
   .snp_valid  (snp_valid),
   .snp_write  (snp_write),
   .snp_idx    (snp_idx),
   .snp_hit    (snp_hit),
   .mem_wr     (mem_wr),
   .copyback   (copyback),
   .snp_shared (snp_shared),
   .line_flat  (line_flat)
);

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
   localparam int NL = 16;
   localparam int IW = $clog2(NL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lreq_valid = 0, lreq_write = 0, lreq_hit = 0, shared_in = 0;
   logic snp_valid = 0, snp_write = 0, snp_hit = 0;
   logic [IW-1:0] lreq_idx = '0, snp_idx = '0;
   logic [1:0] cur_state;
   logic mem_wr, evict_wb, copyback, snp_shared;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   mesi_line_ctrl #(.NUM_LINES(NL)) uut (
      .clk(clk), .rst_n(rst_n),
      .lreq_valid(lreq_valid), .lreq_write(lreq_write), .lreq_idx(lreq_idx),
      .lreq_hit(lreq_hit), .shared_in(shared_in),
      .snp_valid(snp_valid), .snp_write(snp_write), .snp_idx(snp_idx),
      .snp_hit(snp_hit),
      .cur_state(cur_state), .mem_wr(mem_wr), .evict_wb(evict_wb),
      .copyback(copyback), .snp_shared(snp_shared)
   );

   typedef struct packed {
      logic       lv, lw;
      logic [3:0] li;
      logic       lh, shin;
      logic       sv, sw;
      logic [3:0] si;
      logic       sh;
      logic [1:0] e_cur;
      logic       e_wt, e_wb, e_cb, e_sh;
      logic [7:0] req;
   } vec_t;

   // states: I=0 S=1 E=2 M=3; peek rows have lv=0
   localparam int NV = 32;
   localparam vec_t VECS [NV] = '{
      '{0,0,4'd1,0,0, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd1},  // R1 reset Invalid
      '{1,0,4'd1,0,0, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd3},  // R3 miss, alone
      '{0,0,4'd1,0,0, 0,0,4'd0,0, 2'd2,0,0,0,0, 8'd3},  // R3 -> E
      '{1,0,4'd1,1,0, 0,0,4'd0,0, 2'd2,0,0,0,0, 8'd2},  // R2 read hit
      '{1,0,4'd2,0,1, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd3},  // R3 miss, shared
      '{0,0,4'd2,0,0, 0,0,4'd0,0, 2'd1,0,0,0,0, 8'd3},  // R3 -> S
      '{1,1,4'd2,1,0, 0,0,4'd0,0, 2'd1,1,0,0,0, 8'd4},  // R4 write hit S
      '{1,1,4'd2,1,0, 0,0,4'd0,0, 2'd2,0,0,0,0, 8'd5},  // R5 write hit E
      '{0,0,4'd2,0,0, 0,0,4'd0,0, 2'd3,0,0,0,0, 8'd5},  // R5 -> M
      '{1,1,4'd3,0,0, 0,0,4'd0,0, 2'd0,1,0,0,0, 8'd6},  // R6 write miss
      '{0,0,4'd3,0,0, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd6},  // R6 stays I
      '{0,0,4'd2,0,0, 1,0,4'd2,1, 2'd1,0,0,1,1, 8'd7},  // R7 snoop rd M
      '{0,0,4'd2,0,0, 0,0,4'd0,0, 2'd1,0,0,0,0, 8'd7},  // R7 -> S
      '{0,0,4'd0,0,0, 1,0,4'd1,1, 2'd0,0,0,0,1, 8'd7},  // R7 snoop rd E
      '{0,0,4'd1,0,0, 0,0,4'd0,0, 2'd1,0,0,0,0, 8'd7},  // R7 -> S
      '{0,0,4'd5,0,0, 1,1,4'd1,1, 2'd0,0,0,0,1, 8'd8},  // R8 snoop wr
      '{0,0,4'd1,0,0, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd8},  // R8 -> I
      '{0,0,4'd4,0,0, 1,0,4'd4,1, 2'd0,0,0,0,0, 8'd9},  // R9 invalid line
      '{0,0,4'd2,0,0, 1,0,4'd2,0, 2'd1,0,0,0,0, 8'd9},  // R9 tag miss
      '{1,0,4'd6,0,0, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd10}, // R10 fill E
      '{1,1,4'd6,1,0, 0,0,4'd0,0, 2'd2,0,0,0,0, 8'd10}, // R10 make M
      '{1,0,4'd6,0,0, 0,0,4'd0,0, 2'd3,0,1,0,0, 8'd10}, // R10 evict M
      '{0,0,4'd6,0,0, 0,0,4'd0,0, 2'd2,0,0,0,0, 8'd10}, // R10 refilled E
      '{1,0,4'd2,0,1, 0,0,4'd0,0, 2'd1,0,0,0,0, 8'd10}, // R10 evict S, no wb
      '{1,1,4'd6,1,0, 1,1,4'd6,1, 2'd0,1,0,0,1, 8'd11}, // R11 snoop wr first
      '{0,0,4'd6,0,0, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd11}, // R11 -> I
      '{1,1,4'd2,1,0, 0,0,4'd0,0, 2'd1,1,0,0,0, 8'd4},  // R4 S -> E
      '{1,1,4'd2,1,0, 0,0,4'd0,0, 2'd2,0,0,0,0, 8'd5},  // R5 E -> M
      '{1,0,4'd2,1,0, 1,0,4'd2,1, 2'd1,0,0,1,1, 8'd11}, // R11 snoop rd + hit
      '{0,0,4'd2,0,0, 0,0,4'd0,0, 2'd1,0,0,0,0, 8'd11}, // R11 -> S
      '{1,0,4'd7,1,0, 0,0,4'd0,0, 2'd0,0,0,0,0, 8'd3},  // R3 hit on Invalid
      '{0,0,4'd7,0,0, 0,0,4'd0,0, 2'd2,0,0,0,0, 8'd3}   // R3 -> E
   };

   task automatic drive(input vec_t v);
      lreq_valid = v.lv; lreq_write = v.lw; lreq_idx = v.li; lreq_hit = v.lh;
      shared_in  = v.shin;
      snp_valid  = v.sv; snp_write = v.sw; snp_idx = v.si; snp_hit = v.sh;
   endtask

   task automatic check(input vec_t v, input int row);
      logic [5:0] act, exp;
      act = {cur_state, mem_wr, evict_wb, copyback, snp_shared};
      exp = {v.e_cur, v.e_wt, v.e_wb, v.e_cb, v.e_sh};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d row %0d: {cur,wt,wb,cb,sh} actual %b expected %b",
                  v.req, row, act, exp);
      end
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      vec_t idle;
      idle = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VECS[k]);
         #4;
         check(VECS[k], k);
      end

      // R1: mid-run reset clears a Shared line; outputs quiet when idle
      @(negedge clk);
      drive(idle);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      idle.li = 4'd2; idle.req = 8'd1;
      drive(idle);
      #4;
      check(idle, 100);
      idle.li = 4'd7;
      drive(idle);
      #1;
      check(idle, 101);

      // R3: read miss after reset with shared_in high fills as Shared
      @(negedge clk);
      idle = '0;
      idle.lv = 1; idle.li = 4'd9; idle.shin = 1; idle.req = 8'd3;
      drive(idle);
      #4;
      check(idle, 102);
      @(negedge clk);
      idle = '0; idle.li = 4'd9; idle.e_cur = 2'd1; idle.req = 8'd3;
      drive(idle);
      #4;
      check(idle, 103);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule